// File: doc/BRIEF.md
# Two-Thread Shared-Table Branch Direction Predictor

This block predicts the direction of conditional branches for an in-order fetch front end that interleaves two hardware threads. A single table of 4096 two-bit saturating counters is shared by both threads. Each thread has its own 6-bit register of recent outcomes. A lookup forms its table index by XOR-ing twelve PC bits with the requesting thread's outcome register. The fetch stage makes one lookup per thread fetch slot, and a fetch slot may carry up to four instructions.

The lookup path is purely combinational. The fetch stage presents a thread number and a branch PC, and in the same cycle it receives a taken/not-taken guess and the history value that produced it. The fetch stage carries that history value down the pipe with the branch. When the branch resolves, the execute stage returns the thread number, the PC, the real outcome and the carried history value. In that cycle the block trains the addressed counter and shifts the outcome into the thread's history register. The reset input is asserted asynchronously and released through a two-stage synchronizer.

Top module: `bp_gshare2t`

## Requirements
- R1: While reset is asserted, and until the first update after its release, every lookup from either thread returns not-taken (pred_taken=0) and pred_hist=0. All counters reset to 1 (weakly not-taken) and both histories reset to 0.
- R2: The table index is pc[13:2] XOR {6'b0, history}, where history is 6 bits. A lookup uses the current history of pred_tid. An update uses upd_hist.
- R3: pred_taken is bit 1 of the addressed counter, so counter values 2 and 3 predict taken.
- R4: An update with upd_taken=1 raises the counter by one and holds it at 3. A counter at 3 that takes one not-taken update still predicts taken.
- R5: An update with upd_taken=0 lowers the counter by one and holds it at 0. A counter at 0 that takes one taken update still predicts not-taken.
- R6: An update shifts the history of upd_tid left by one bit, places upd_taken in bit 0 and drops the old bit 5. pred_hist shows the history of pred_tid.
- R7: An update never changes the history of the other thread. The counter table is shared, so an update from one thread changes the lookup of the other thread whenever the two indices are equal.
- R8: When a lookup and an update address the same entry in one cycle, the lookup returns the counter value from before the update. The next cycle shows the new value.
- R9: An update trains the entry selected by upd_hist, even when the thread's current history holds a different value.
- R10: While upd_valid=0, the counters and histories keep their values, whatever the other update inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| pred_tid | input | 1 | Thread number of the lookup |
| pred_pc | input | 32 | Branch PC of the lookup |
| pred_taken | output | 1 | Predicted direction, 1 = taken (combinational) |
| pred_hist | output | 6 | History of pred_tid used by this lookup |
| upd_valid | input | 1 | Update strobe |
| upd_tid | input | 1 | Thread number of the resolved branch |
| upd_pc | input | 32 | PC of the resolved branch |
| upd_taken | input | 1 | Resolved outcome, 1 = taken |
| upd_hist | input | 6 | History snapshot returned with the resolved branch |

## Verification
The hardest case to reach is an update whose snapshot history differs from the thread's current history. In that case the trained entry is invisible to a plain lookup at the same PC. The bench first moves the thread's history with other updates. It then sends an update with an older snapshot. Finally it computes a different lookup PC whose low bits, XOR-ed with the new current history, land on the trained entry. A second difficult case is a lookup and an update that hit the same entry in one cycle. The bench drives both on the same low clock phase, samples the lookup before the edge and samples again after it.

// File: rtl/bp_pkg.sv
package bp_pkg;
  localparam int CTR_W = 2;
  typedef logic [CTR_W-1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'd1;
  localparam ctr_t CTR_MAX   = 2'd3;
  localparam ctr_t CTR_MIN   = 2'd0;

  function automatic ctr_t ctr_train(input ctr_t cur, input logic taken);
    ctr_t res;
    if (taken) res = (cur == CTR_MAX) ? cur : cur + 2'd1;
    else       res = (cur == CTR_MIN) ? cur : cur - 2'd1;
    return res;
  endfunction
endpackage

// File: rtl/bp_hist_regs.sv
module bp_hist_regs #(
  parameter int HIST_W  = 6,
  parameter int NUM_THR = 2,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      upd_valid,
  input  logic [TID_W-1:0]          upd_tid,
  input  logic                      upd_taken,
  output logic [NUM_THR*HIST_W-1:0] hist_flat
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_thr
    logic [HIST_W-1:0] hist_q, hist_d;
    logic              hist_en;

    always_comb begin
      hist_en = upd_valid && (upd_tid == TID_W'(t));
      hist_d  = {hist_q[HIST_W-2:0], upd_taken};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       hist_q <= '0;
      else if (hist_en) hist_q <= hist_d;
    end

    assign hist_flat[t*HIST_W +: HIST_W] = hist_q;
  end
endmodule

// File: rtl/bp_index.sv
module bp_index #(
  parameter int PC_W   = 32,
  parameter int IDX_W  = 12,
  parameter int HIST_W = 6
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [IDX_W-1:0]  idx
);
  always_comb idx = pc[IDX_W+1:2] ^ IDX_W'(hist);
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int IDX_W   = 12,
  localparam int DEPTH  = 1 << IDX_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken,
  output ctr_t             wr_old
);
  ctr_t mem_q [DEPTH];
  ctr_t wr_new;

  always_comb begin
    rd_ctr = mem_q[rd_idx];
    wr_old = mem_q[wr_idx];
    wr_new = ctr_train(wr_old, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= CTR_RESET;
    end else if (wr_en) begin
      mem_q[wr_idx] <= wr_new;
    end
  end
endmodule

// File: rtl/bp_gshare2t.sv
module bp_gshare2t
  import bp_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int IDX_W   = 12,
  parameter int HIST_W  = 6,
  parameter int NUM_THR = 2,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TID_W-1:0]  pred_tid,
  input  logic [PC_W-1:0]   pred_pc,
  output logic              pred_taken,
  output logic [HIST_W-1:0] pred_hist,
  input  logic              upd_valid,
  input  logic [TID_W-1:0]  upd_tid,
  input  logic [PC_W-1:0]   upd_pc,
  input  logic              upd_taken,
  input  logic [HIST_W-1:0] upd_hist
);
  logic [1:0]                rst_sync_q;
  logic                      rst_int_n;
  logic [NUM_THR*HIST_W-1:0] hist_flat;
  logic [IDX_W-1:0]          pred_idx, upd_idx;
  ctr_t                      pred_ctr, upd_old;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  bp_hist_regs #(.HIST_W(HIST_W), .NUM_THR(NUM_THR)) hist_i (
    .clk(clk), .rst_n(rst_int_n), .upd_valid(upd_valid),
    .upd_tid(upd_tid), .upd_taken(upd_taken), .hist_flat(hist_flat));

  always_comb pred_hist = hist_flat[pred_tid*HIST_W +: HIST_W];

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) pidx_i (
    .pc(pred_pc), .hist(pred_hist), .idx(pred_idx));

  bp_index #(.PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W)) uidx_i (
    .pc(upd_pc), .hist(upd_hist), .idx(upd_idx));

  bp_ctr_table #(.IDX_W(IDX_W)) tbl_i (
    .clk(clk), .rst_n(rst_int_n), .rd_idx(pred_idx), .rd_ctr(pred_ctr),
    .wr_en(upd_valid), .wr_idx(upd_idx), .wr_taken(upd_taken),
    .wr_old(upd_old));

  always_comb pred_taken = pred_ctr[CTR_W-1];
endmodule

// File: rtl/bp_gshare2t_chk.sv
module bp_gshare2t_chk #(
  parameter int IDX_W   = 12,
  parameter int HIST_W  = 6,
  parameter int NUM_THR = 2,
  localparam int TID_W  = (NUM_THR > 1) ? $clog2(NUM_THR) : 1
) (
  input logic                      clk,
  input logic                      rst_int_n,
  input logic                      upd_valid,
  input logic [TID_W-1:0]          upd_tid,
  input logic                      upd_taken,
  input logic [NUM_THR*HIST_W-1:0] hist_flat,
  input logic [IDX_W-1:0]          pred_idx,
  input logic [IDX_W-1:0]          upd_idx,
  input logic [1:0]                upd_old,
  input logic                      pred_taken
);
  for (genvar t = 0; t < NUM_THR; t++) begin : g_chk
    AST_HIST_SHIFT: assert property (@(posedge clk) disable iff (!rst_int_n)
      upd_valid && upd_tid == TID_W'(t) |=>
        hist_flat[t*HIST_W +: HIST_W] ==
        {$past(hist_flat[t*HIST_W +: HIST_W-1]), $past(upd_taken)}); // R6
    AST_OTHER_THR_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
      upd_valid && upd_tid != TID_W'(t) |=>
        $stable(hist_flat[t*HIST_W +: HIST_W])); // R7
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_int_n)
    !upd_valid |=> $stable(hist_flat)); // R10

  AST_SAT_HIGH: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid && upd_taken && upd_old == 2'd3 |=>
      (pred_idx != $past(upd_idx)) || pred_taken); // R4

  AST_SAT_LOW: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid && !upd_taken && upd_old == 2'd0 |=>
      (pred_idx != $past(upd_idx)) || !pred_taken); // R5

  AST_TRAIN_UP: assert property (@(posedge clk) disable iff (!rst_int_n)
    upd_valid && upd_taken && upd_old == 2'd1 |=>
      (pred_idx != $past(upd_idx)) || pred_taken); // R3
endmodule

bind bp_gshare2t bp_gshare2t_chk #(
  .IDX_W(IDX_W), .HIST_W(HIST_W), .NUM_THR(NUM_THR)
) chk_i (
  .clk(clk), .rst_int_n(rst_int_n), .upd_valid(upd_valid),
  .upd_tid(upd_tid), .upd_taken(upd_taken), .hist_flat(hist_flat),
  .pred_idx(pred_idx), .upd_idx(upd_idx), .upd_old(upd_old),
  .pred_taken(pred_taken));

// File: tb/bp_gshare2t_tb_top.sv
`timescale 1ns/1ps
module bp_gshare2t_tb_top;
  localparam int PC_W = 32, IDX_W = 12, HIST_W = 6, NUM_THR = 2;
  localparam int DEPTH = 1 << IDX_W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              pred_tid;
  logic [PC_W-1:0]   pred_pc;
  logic              pred_taken;
  logic [HIST_W-1:0] pred_hist;
  logic              upd_valid;
  logic              upd_tid;
  logic [PC_W-1:0]   upd_pc;
  logic              upd_taken;
  logic [HIST_W-1:0] upd_hist;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [1:0]        m_ctr [DEPTH];
  logic [HIST_W-1:0] m_hist [NUM_THR];

  always #2.5 clk = ~clk;

  bp_gshare2t dut_i (
    .clk(clk), .rst_n(rst_n), .pred_tid(pred_tid), .pred_pc(pred_pc),
    .pred_taken(pred_taken), .pred_hist(pred_hist), .upd_valid(upd_valid),
    .upd_tid(upd_tid), .upd_pc(upd_pc), .upd_taken(upd_taken),
    .upd_hist(upd_hist));

  function automatic logic [IDX_W-1:0] m_idx(input logic [PC_W-1:0] pc,
                                             input logic [HIST_W-1:0] h);
    return pc[IDX_W+1:2] ^ {{(IDX_W-HIST_W){1'b0}}, h};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic m_train(input logic tid, input logic [PC_W-1:0] pc,
                         input logic tk, input logic [HIST_W-1:0] h);
    logic [IDX_W-1:0] i;
    i = m_idx(pc, h);
    if (tk)  m_ctr[i] = (m_ctr[i] == 2'd3) ? 2'd3 : m_ctr[i] + 2'd1;
    else     m_ctr[i] = (m_ctr[i] == 2'd0) ? 2'd0 : m_ctr[i] - 2'd1;
    m_hist[tid] = {m_hist[tid][HIST_W-2:0], tk};
  endtask

  task automatic do_upd(input logic tid, input logic [PC_W-1:0] pc,
                        input logic tk, input logic [HIST_W-1:0] h);
    @(negedge clk);
    upd_tid = tid; upd_pc = pc; upd_taken = tk; upd_hist = h; upd_valid = 1'b1;
    @(posedge clk);
    m_train(tid, pc, tk, h);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  task automatic check_pred(input string req, input logic tid, input logic [PC_W-1:0] pc);
    @(negedge clk);
    pred_tid = tid; pred_pc = pc;
    #1;
    chk({req, " hist"}, 32'(pred_hist), 32'(m_hist[tid]));
    chk({req, " dir"}, 32'(pred_taken), 32'(m_ctr[m_idx(pc, m_hist[tid])][1]));
  endtask

  task automatic t_reset;
    // R1: no update yet, every lookup not taken, histories zero
    check_pred("R1", 1'b0, 32'h0000_1000);
    check_pred("R1", 1'b1, 32'hdead_beec);
    check_pred("R1", 1'b0, 32'h0000_3ffc);
  endtask

  task automatic t_saturate;
    logic [PC_W-1:0] pc = 32'h0000_0840;
    // R3: 1 -> 2 predicts taken
    do_upd(1'b1, pc, 1'b1, m_hist[1]);
    chk("R3 taken after one train", 32'(m_ctr[m_idx(pc, 6'd0)]), 32'd2);
    check_pred("R3", 1'b0, pc);
    // R4: push to 3 and beyond, then one not-taken still taken
    for (int k = 0; k < 4; k++) do_upd(1'b1, pc, 1'b1, 6'd0);
    do_upd(1'b1, pc, 1'b0, 6'd0);
    check_pred("R4", 1'b0, pc);
    chk("R4 model level", 32'(m_ctr[m_idx(pc, 6'd0)]), 32'd2);
    // R5: drive to 0 and beyond, then one taken still not taken
    for (int k = 0; k < 5; k++) do_upd(1'b1, pc, 1'b0, 6'd0);
    do_upd(1'b1, pc, 1'b1, 6'd0);
    check_pred("R5", 1'b0, pc);
  endtask

  task automatic t_history;
    // R6: thread 0 history collects outcomes; older bits fall off
    logic [HIST_W-1:0] h1_before;
    h1_before = m_hist[1];
    do_upd(1'b0, 32'h100, 1'b1, m_hist[0]);
    do_upd(1'b0, 32'h104, 1'b0, m_hist[0]);
    do_upd(1'b0, 32'h108, 1'b1, m_hist[0]);
    check_pred("R6", 1'b0, 32'h200);
    chk("R6 value", 32'(m_hist[0]), 32'(6'b000101));
    for (int k = 0; k < 5; k++) do_upd(1'b0, 32'h300, 1'b1, m_hist[0]);
    check_pred("R6 drop", 1'b0, 32'h200);
    // R7: thread 1 history untouched by thread 0 updates
    check_pred("R7", 1'b1, 32'h200);
    chk("R7 other hist", 32'(m_hist[1]), 32'(h1_before));
  endtask

  task automatic t_shared_index;
    // R7/R2: thread 1 trains entry, thread 0 sees it through its own history
    logic [PC_W-1:0] p1, p0;
    p1 = 32'h0000_5a0c;
    do_upd(1'b1, p1, 1'b1, m_hist[1]);
    do_upd(1'b1, p1, 1'b1, m_idx(p1, 6'd0) == m_idx(p1, 6'd0) ? 6'd0 : 6'd0);
    p0 = p1;
    p0[IDX_W+1:2] = m_idx(p1, 6'd0) ^ {{(IDX_W-HIST_W){1'b0}}, m_hist[0]};
    check_pred("R7 shared", 1'b0, p0);
    check_pred("R2 index", 1'b0, p0 ^ 32'h4);
  endtask

  task automatic t_same_cycle;
    // R8: lookup and update on one entry in one cycle
    logic [PC_W-1:0] pc = 32'h0000_0a80;
    logic [1:0] old;
    @(negedge clk);
    old = m_ctr[m_idx(pc, m_hist[1])];
    pred_tid = 1'b1; pred_pc = pc;
    upd_tid = 1'b1; upd_pc = pc; upd_taken = 1'b1; upd_hist = m_hist[1];
    upd_valid = 1'b1;
    #1;
    chk("R8 old value", 32'(pred_taken), 32'(old[1]));
    @(posedge clk);
    m_train(1'b1, pc, 1'b1, upd_hist);
    @(negedge clk);
    upd_valid = 1'b0;
    pred_pc = pc ^ {20'd0, m_hist[1] ^ upd_hist, 2'b00};
    #1;
    chk("R8 new value", 32'(pred_taken), 32'(m_ctr[m_idx(pc, upd_hist)][1]));
  endtask

  task automatic t_snapshot;
    // R9: update with stale snapshot trains snapshot entry
    logic [PC_W-1:0] p, q;
    logic [HIST_W-1:0] snap;
    p = 32'h0000_2220;
    snap = 6'b100110;
    do_upd(1'b0, p, 1'b1, snap);
    do_upd(1'b0, p, 1'b1, snap);
    q = p;
    q[IDX_W+1:2] = m_idx(p, snap) ^ {{(IDX_W-HIST_W){1'b0}}, m_hist[0]};
    check_pred("R9 snap entry", 1'b0, q);
    chk("R9 taken", 32'(pred_taken), 32'd1);
    check_pred("R9 current entry", 1'b0, p);
  endtask

  task automatic t_idle;
    // R10: update inputs toggle with upd_valid low
    logic [PC_W-1:0] pc = 32'h0000_0e00;
    @(negedge clk);
    upd_valid = 1'b0;
    for (int k = 0; k < 6; k++) begin
      upd_tid = k[0]; upd_pc = pc; upd_taken = 1'b1; upd_hist = m_hist[k[0]];
      @(negedge clk);
    end
    check_pred("R10", 1'b0, pc);
    check_pred("R10", 1'b1, pc);
    chk("R10 still weak", 32'(pred_taken), 32'd0);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) m_ctr[i] = 2'd1;
    for (int t = 0; t < NUM_THR; t++) m_hist[t] = '0;
    rst_n = 1'b0;
    pred_tid = 1'b0; pred_pc = '0;
    upd_valid = 1'b0; upd_tid = 1'b0; upd_pc = '0; upd_taken = 1'b0; upd_hist = '0;
    #1;
    chk("R1 in reset", 32'(pred_taken), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_saturate();
    t_history();
    t_shared_index();
    t_same_cycle();
    t_snapshot();
    t_idle();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule